// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block sits between an internal requester and a 16-bit asynchronous memory bus. The requester presents one request at a time: an address, write data, a read/write flag and a flag that picks program space or data space. The controller runs the access on the external bus, then returns a one-cycle completion pulse. For reads, the captured data is returned along with the pulse.

Each access passes through four states, always in this order:

- `ST_IDLE`: the block waits and grants requests.
- `ST_SETUP`: one cycle in which the address and the space select are set up.
- `ST_STROBE`: the read or write strobe is held low for one base cycle plus the programmed number of wait states.
- `ST_HOLD`: one cycle in which the strobe is high again but the address and select are unchanged.

The transitions are:

- IDLE to SETUP on an accepted request.
- SETUP to STROBE unconditionally.
- STROBE to itself while the wait counter is non-zero, then STROBE to HOLD.
- HOLD back to IDLE.

Each space has its own 2-bit wait-state code. The code selects 0, 4, 8 or 12 wait states. Read data is latched at the clock edge where the read strobe rises. The data bus output enable covers the write strobe with one cycle of margin on each side. This models the pad tri-state control.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is low, both strobes and both space selects are high, `ext_doe` and `rsp_ready` are low, and `req_gnt` is high.
- R2: A request is accepted only when `req_valid` is high and `req_gnt` is high. `req_gnt` is high only in ST_IDLE. An accepted access spends exactly 1 cycle in ST_SETUP, then 1+W cycles with its strobe low, then 1 cycle in ST_HOLD, and then returns to ST_IDLE.
- R3: The wait count W equals 4 times the 2-bit code, so codes 00, 01, 10 and 11 give 0, 4, 8 and 12. A program-space access uses `ws_prog_code` and a data-space access uses `ws_data_code`. The code is sampled at acceptance, and later changes have no effect on that access.
- R4: `ext_ps_n` is low from SETUP through HOLD of a program-space access (`req_prog`=1). `ext_ds_n` is low over the same span of a data-space access (`req_prog`=0). Both are high in ST_IDLE, and they are never low together.
- R5: `ext_addr` equals the accepted address from SETUP through HOLD, even if `req_addr` changes after acceptance.
- R6: For a read (`req_write`=0), `ext_rd_n` is low during the strobe cycles, while `ext_wr_n` stays high and `ext_doe` stays low. `rsp_rdata` becomes the value `ext_din` had in the last strobe cycle and holds it until the next read completes.
- R7: For a write (`req_write`=1), `ext_wr_n` is low during the strobe cycles while `ext_rd_n` stays high. `ext_doe` is high from SETUP through HOLD, and `ext_dout` carries the accepted write data.
- R8: `ext_doe` is low whenever the block is in ST_IDLE.
- R9: `rsp_ready` is high for exactly one cycle per access, in the ST_HOLD cycle.
- R10: A request presented while the block is busy is stalled: `req_gnt` stays low. The stalled request is accepted on the edge that ends the ST_IDLE cycle following ST_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prog | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| ws_prog_code | input | CODE_W | Wait-state code for program space |
| ws_data_code | input | CODE_W | Wait-state code for data space |
| req_gnt | output | 1 | Block idle; a valid request is taken this cycle |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Latched read data |
| ext_addr | output | AW | External address bus |
| ext_dout | output | DW | External data bus, driven value |
| ext_din | input | DW | External data bus, sampled value |
| ext_doe | output | 1 | Data bus output enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_ps_n | output | 1 | Program-space select, active low |
| ext_ds_n | output | 1 | Data-space select, active low |

## Verification
The bench builds the block with its defaults: a 16-bit address and data bus, a 2-bit wait code and a step of 4. With these values every wait count, from 0 up to the largest strobe of 13 cycles, is in reach. The sweep covers all four codes in both spaces and both directions. In every access the code of the unused space differs from the code in use, and both codes and the address are scrambled right after acceptance. A separate sequence holds a second request against a busy block to exercise the stall and the restart immediately after the hold cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } xmem_state_e;

    localparam int SPACE_DATA = 0;
    localparam int SPACE_PROG = 1;
    localparam int NUM_SPACES = 2;
endpackage

// File: rtl/xmem_wait_sel.sv
module xmem_wait_sel #(
    parameter int CODE_W  = 2,
    parameter int WS_STEP = 4,
    parameter int CNT_W   = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  wait_cnt
);
    // Wait count is the code scaled by the step size.
    assign wait_cnt = CNT_W'(int'(code) * WS_STEP);
endmodule

// File: rtl/xmem_rd_latch.sv
module xmem_rd_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (cap_en) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_prog,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [CNT_W-1:0] ws_sel,
    output logic             req_gnt,
    output logic             rsp_ready,
    output logic             cap_en,
    output logic [AW-1:0]    ext_addr,
    output logic [DW-1:0]    ext_dout,
    output logic             ext_doe,
    output logic             ext_rd_n,
    output logic             ext_wr_n,
    output logic             ext_ps_n,
    output logic             ext_ds_n
);
    xmem_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             lat_write;
    logic             lat_prog;
    logic [AW-1:0]    lat_addr;
    logic [DW-1:0]    lat_wdata;

    // State register with the latched request and the wait counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lat_write <= 1'b0;
            lat_prog  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_SETUP;
                        cnt       <= ws_sel;
                        lat_write <= req_write;
                        lat_prog  <= req_prog;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                    end
                end
                ST_SETUP: state <= ST_STROBE;
                ST_STROBE: begin
                    if (cnt == '0) begin
                        state <= ST_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state and the latched request.
    always_comb begin
        req_gnt   = 1'b0;
        rsp_ready = 1'b0;
        cap_en    = 1'b0;
        ext_doe   = 1'b0;
        ext_rd_n  = 1'b1;
        ext_wr_n  = 1'b1;
        ext_ps_n  = 1'b1;
        ext_ds_n  = 1'b1;
        unique case (state)
            ST_IDLE: req_gnt = 1'b1;
            ST_SETUP: begin
                ext_ps_n = !lat_prog;
                ext_ds_n = lat_prog;
                ext_doe  = lat_write;
            end
            ST_STROBE: begin
                ext_ps_n = !lat_prog;
                ext_ds_n = lat_prog;
                ext_doe  = lat_write;
                ext_rd_n = lat_write;
                ext_wr_n = !lat_write;
                cap_en   = !lat_write && (cnt == '0);
            end
            ST_HOLD: begin
                ext_ps_n  = !lat_prog;
                ext_ds_n  = lat_prog;
                ext_doe   = lat_write;
                rsp_ready = 1'b1;
            end
            default: req_gnt = 1'b0;
        endcase
    end

    assign ext_addr = lat_addr;
    assign ext_dout = lat_wdata;
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int CODE_W  = 2,
    parameter int WS_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_prog,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [CODE_W-1:0] ws_prog_code,
    input  logic [CODE_W-1:0] ws_data_code,
    output logic              req_gnt,
    output logic              rsp_ready,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_dout,
    input  logic [DW-1:0]     ext_din,
    output logic              ext_doe,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_ps_n,
    output logic              ext_ds_n
);
    localparam int MAX_WS = ((1 << CODE_W) - 1) * WS_STEP;
    localparam int CNT_W  = (MAX_WS < 1) ? 1 : $clog2(MAX_WS + 1);

    logic [CODE_W-1:0] codes [NUM_SPACES];
    logic [CNT_W-1:0]  waits [NUM_SPACES];
    logic [CNT_W-1:0]  ws_sel;
    logic              cap_en;

    assign codes[SPACE_DATA] = ws_data_code;
    assign codes[SPACE_PROG] = ws_prog_code;

    // One wait-state decoder per address space.
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        xmem_wait_sel #(
            .CODE_W (CODE_W),
            .WS_STEP(WS_STEP),
            .CNT_W  (CNT_W)
        ) u_wsel (
            .code    (codes[g]),
            .wait_cnt(waits[g])
        );
    end

    assign ws_sel = req_prog ? waits[SPACE_PROG] : waits[SPACE_DATA];

    xmem_fsm #(
        .AW   (AW),
        .DW   (DW),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_prog (req_prog),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .ws_sel   (ws_sel),
        .req_gnt  (req_gnt),
        .rsp_ready(rsp_ready),
        .cap_en   (cap_en),
        .ext_addr (ext_addr),
        .ext_dout (ext_dout),
        .ext_doe  (ext_doe),
        .ext_rd_n (ext_rd_n),
        .ext_wr_n (ext_wr_n),
        .ext_ps_n (ext_ps_n),
        .ext_ds_n (ext_ds_n)
    );

    xmem_rd_latch #(
        .DW(DW)
    ) u_rdl (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .din   (ext_din),
        .dout  (rsp_rdata)
    );
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_gnt,
    input logic          rsp_ready,
    input logic [AW-1:0] ext_addr,
    input logic          ext_doe,
    input logic          ext_rd_n,
    input logic          ext_wr_n,
    input logic          ext_ps_n,
    input logic          ext_ds_n
);
    logic strobe_on;
    assign strobe_on = !ext_rd_n || !ext_wr_n;

    p_no_dual_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_ps_n && !ext_ds_n));

    p_select_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |-> (!ext_ps_n || !ext_ds_n));

    p_idle_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_gnt |-> !ext_doe);

    p_write_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> ext_doe);

    p_read_floats_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> !ext_doe);

    p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    p_ready_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> $past(strobe_on));

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |=> $stable(ext_addr));

    p_busy_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on || rsp_ready) |-> !req_gnt);
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_gnt  (req_gnt),
    .rsp_ready(rsp_ready),
    .ext_addr (ext_addr),
    .ext_doe  (ext_doe),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n),
    .ext_ps_n (ext_ps_n),
    .ext_ds_n (ext_ds_n)
);

// File: tb/xmem_bus_ctrl_tb.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_prog = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, ext_din = '0;
    logic [1:0]  ws_prog_code = '0, ws_data_code = '0;
    logic        req_gnt, rsp_ready, ext_doe, ext_rd_n, ext_wr_n, ext_ps_n, ext_ds_n;
    logic [15:0] rsp_rdata, ext_addr, ext_dout;

    int total = 0;
    int bad = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    xmem_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_prog(req_prog), .req_addr(req_addr), .req_wdata(req_wdata),
        .ws_prog_code(ws_prog_code), .ws_data_code(ws_data_code),
        .req_gnt(req_gnt), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_doe(ext_doe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_ps_n(ext_ps_n), .ext_ds_n(ext_ds_n)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input bit wr, input bit prg, input logic [15:0] a,
                              input logic [15:0] wd, input logic [1:0] pc,
                              input logic [1:0] dc, input logic [15:0] rv);
        int w;
        logic [1:0] sel_exp;
        w = 4 * int'(prg ? pc : dc);
        sel_exp = prg ? 2'b01 : 2'b10;
        @(negedge clk);
        chk(req_gnt == 1'b1, "R2 grant in idle", 32'(req_gnt), 1);
        req_valid = 1'b1; req_write = wr; req_prog = prg; req_addr = a;
        req_wdata = wd; ws_prog_code = pc; ws_data_code = dc; ext_din = ~rv;
        // setup cycle
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; ws_prog_code = ~pc; ws_data_code = ~dc;
        chk(req_gnt == 1'b0, "R2 no grant in setup", 32'(req_gnt), 0);
        chk({ext_rd_n, ext_wr_n} == 2'b11, "R2 strobes high in setup",
            32'({ext_rd_n, ext_wr_n}), 3);
        chk({ext_ps_n, ext_ds_n} == sel_exp, "R4 select in setup",
            32'({ext_ps_n, ext_ds_n}), 32'(sel_exp));
        chk(ext_addr == a, "R5 address in setup", 32'(ext_addr), 32'(a));
        chk(ext_doe == wr, "R7 output enable in setup", 32'(ext_doe), 32'(wr));
        // strobe cycles: 1 + w (R3 wait count)
        for (int i = 0; i <= w; i++) begin
            @(negedge clk);
            chk({ext_rd_n, ext_wr_n} == (wr ? 2'b10 : 2'b01), "R3 strobe low",
                32'({ext_rd_n, ext_wr_n}), wr ? 32'd2 : 32'd1);
            chk({ext_ps_n, ext_ds_n} == sel_exp, "R4 select in strobe",
                32'({ext_ps_n, ext_ds_n}), 32'(sel_exp));
            chk(ext_addr == a, "R5 address in strobe", 32'(ext_addr), 32'(a));
            if (wr) begin
                chk(ext_doe && ext_dout == wd, "R7 write data driven",
                    {15'd0, ext_doe, ext_dout}, {16'd1, wd});
            end else begin
                chk(!ext_doe, "R6 bus released on read", 32'(ext_doe), 0);
            end
            if (i == w) ext_din = rv;
        end
        // hold cycle
        @(negedge clk);
        ext_din = ~rv;
        chk({ext_rd_n, ext_wr_n} == 2'b11, "R3 strobe ended after 1+W",
            32'({ext_rd_n, ext_wr_n}), 3);
        chk(rsp_ready == 1'b1, "R9 ready in hold", 32'(rsp_ready), 1);
        chk({ext_ps_n, ext_ds_n} == sel_exp, "R4 select in hold",
            32'({ext_ps_n, ext_ds_n}), 32'(sel_exp));
        chk(ext_addr == a, "R5 address in hold", 32'(ext_addr), 32'(a));
        chk(ext_doe == wr, "R7 output enable in hold", 32'(ext_doe), 32'(wr));
        if (!wr) begin
            last_rd = rv;
            chk(rsp_rdata == rv, "R6 read data captured", 32'(rsp_rdata), 32'(rv));
        end
        // back to idle
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R9 ready single pulse", 32'(rsp_ready), 0);
        chk(ext_doe == 1'b0, "R8 bus released in idle", 32'(ext_doe), 0);
        chk({ext_ps_n, ext_ds_n} == 2'b11, "R4 selects off in idle",
            32'({ext_ps_n, ext_ds_n}), 3);
        chk(req_gnt == 1'b1, "R2 grant after hold", 32'(req_gnt), 1);
        chk(rsp_rdata == last_rd, "R6 read data held", 32'(rsp_rdata), 32'(last_rd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk({ext_rd_n, ext_wr_n, ext_ps_n, ext_ds_n} == 4'hF, "R1 reset strobes/selects",
            32'({ext_rd_n, ext_wr_n, ext_ps_n, ext_ds_n}), 32'hF);
        chk(!ext_doe && !rsp_ready && req_gnt, "R1 reset doe/ready/gnt",
            32'({ext_doe, rsp_ready, req_gnt}), 1);
        rst_n = 1'b1;

        // Sweep: both spaces, both directions, all codes; other space's code differs.
        for (int sp = 0; sp < 2; sp++) begin
            for (int code = 0; code < 4; code++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [1:0] pc;
                    logic [1:0] dc;
                    pc = (sp == 1) ? 2'(code) : 2'(3 - code);
                    dc = (sp == 1) ? 2'(code + 1) : 2'(code);
                    run_access(d[0], sp[0], 16'(16'h1234 + 16'(code * 97 + sp * 13 + d)),
                               16'(16'hA5C3 ^ 16'(code * 331 + d)), pc, dc,
                               16'(16'h5A00 + 16'(code * 17 + sp * 7 + d)));
                end
            end
        end

        // R10: second request held against a busy block.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_prog = 1'b0; req_addr = 16'h0F0F;
        ws_data_code = 2'b00; ws_prog_code = 2'b01; ext_din = 16'hBEEF;
        @(negedge clk); // setup of A
        req_write = 1'b1; req_prog = 1'b1; req_addr = 16'hC0DE; req_wdata = 16'h7777;
        chk(req_gnt == 1'b0, "R10 stall in setup", 32'(req_gnt), 0);
        @(negedge clk); // strobe of A (one cycle)
        chk(req_gnt == 1'b0 && ext_addr == 16'h0F0F, "R10 stall in strobe",
            {15'd0, req_gnt, ext_addr}, 32'h0F0F);
        @(negedge clk); // hold of A
        chk(req_gnt == 1'b0 && rsp_ready && rsp_rdata == 16'hBEEF, "R10 stall in hold",
            {14'd0, req_gnt, rsp_ready, rsp_rdata}, 32'h1BEEF);
        @(negedge clk); // idle, B accepted at next edge
        chk(req_gnt == 1'b1, "R10 grant after hold", 32'(req_gnt), 1);
        @(negedge clk); // setup of B
        req_valid = 1'b0;
        chk(ext_addr == 16'hC0DE && {ext_ps_n, ext_ds_n} == 2'b01 && ext_doe,
            "R10 stalled request starts",
            {13'd0, ext_ps_n, ext_ds_n, ext_doe, ext_addr}, {16'd3, 16'hC0DE});
        repeat (4) @(negedge clk); // strobe 4+1 cycles (program code 01)
        chk(!ext_wr_n, "R10 stalled write strobe", 32'(ext_wr_n), 0);
        @(negedge clk);
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R10 stalled request completes", 32'(rsp_ready), 1);
        @(negedge clk);
        chk(req_gnt && !ext_doe, "R8 idle after stalled request",
            32'({req_gnt, ext_doe}), 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule